// File: doc/BRIEF.md
# Paired-Page Translation Buffer

This block is a fully associative address translation buffer for 32-bit virtual addresses. Each of its entries maps a pair of adjacent virtual pages (an even page and an odd page) that share one tag. The page size is set per entry by a page mask. Each half of the pair has its own physical frame base, valid bit and dirty bit. A lookup is purely combinational. It takes a virtual address, the current 8-bit address-space identifier and a read/write flag. It returns a physical address, a writable flag and a result code.

The result code separates four cases: a clean translation, no entry matching, a matching entry whose selected half is not valid, and a store to a valid half that is not yet dirty. This lets the consumer raise the right kind of fault. Entries are loaded one at a time through a write port addressed by index, and a write is visible from the next clock edge. Replacement policy and locked entries are left to the surrounding logic.

Top module: `pair_tlb`

## Requirements
- R1: After reset every entry holds all-zero fields. A lookup with ASID 0 of an address in 0x0000_0000..0x0000_1FFF therefore returns code 010 (invalid), and any other lookup returns 001 (no match).
- R2: An entry hits when the virtual address and the stored tag agree on every bit above the effective mask, and either the entry's global bit is set or its stored ASID equals `asid_i`. If no entry hits, the code is 001.
- R3: The effective mask is the stored page mask ORed with 0x1FFF, so address bits 12:0 never take part in the compare, and stored tag bits under the effective mask are ignored.
- R4: The even/odd select is the address bit at the top set bit of the effective mask: bit 12 for a zero page mask, bit 14 for a page mask of 0x0000_6000. Value 0 selects the even half and value 1 selects the odd half.
- R5: If the selected half's valid bit is clear, the code is 010 for both reads and writes.
- R6: A write (`wr_i`=1) to a valid half whose dirty bit is clear gives code 011. A read of a valid half gives code 000 whatever the dirty bit is.
- R7: On code 000, `pa_o` is the selected frame base ORed with the address bits under the half mask (the effective mask shifted right by one). `writable_o` equals the selected dirty bit.
- R8: On any code other than 000, `pa_o` is zero and `writable_o` is 0.
- R9: When several entries hit, the entry with the lowest index supplies the result.
- R10: A write at index `widx_i` with `we_i`=1 changes only that entry and is seen by lookups from the next rising clock edge. Before that edge, lookups still see the old contents.
- R11: Result codes are 000 match, 001 no match, 010 invalid, 011 dirty fault. No other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Load the entry at `widx_i` |
| widx_i | input | 4 | Index of the entry to load |
| w_tag_i | input | 32 | Virtual tag (pair base) to store |
| w_mask_i | input | 32 | Page mask to store (contiguous ones from bit 13 up) |
| w_asid_i | input | 8 | ASID to store |
| w_glob_i | input | 1 | Global bit to store |
| w_pfn0_i | input | 32 | Even-half physical base |
| w_v0_i | input | 1 | Even-half valid |
| w_d0_i | input | 1 | Even-half dirty |
| w_pfn1_i | input | 32 | Odd-half physical base |
| w_v1_i | input | 1 | Odd-half valid |
| w_d1_i | input | 1 | Odd-half dirty |
| va_i | input | 32 | Virtual address to translate |
| asid_i | input | 8 | Current ASID |
| wr_i | input | 1 | 1 for a store access, 0 for a load |
| pa_o | output | 32 | Translated physical address, zero on a fault |
| writable_o | output | 1 | Store permitted to the translated page |
| res_o | output | 3 | Result code |

## Verification
The bench targets the select bit for large pages. An address with bit 12 set inside a 16 KB page must stay on the even half, and a design that always used bit 12 would hand back the odd frame. It checks that junk in the stored tag's low bits does not spoil a match, and that a store to a clean page faults while a load from the same page passes. It also checks that an invalid half faults for both kinds of access, which a design that checks only the dirty bit on stores would miss. Overlapping entries are loaded to confirm that the lowest index wins, since a reversed priority encoder returns the other frame. A lookup in the same cycle as a load must still see the old contents, which a write-through bypass would break.

// File: rtl/pair_tlb_pkg.sv
package pair_tlb_pkg;
  typedef enum logic [2:0] {
    RES_MATCH = 3'b000,
    RES_MISS  = 3'b001,
    RES_INVAL = 3'b010,
    RES_DIRTY = 3'b011
  } res_e;
endpackage

// File: rtl/pair_tlb_entry.sv
module pair_tlb_entry #(
  parameter int ADDR_W   = 32,
  parameter int ASID_W   = 8,
  parameter int PAGE_LSB = 12,
  parameter int IDX_W    = 4,
  parameter int IDX      = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [ADDR_W-1:0] w_tag_i,
  input  logic [ADDR_W-1:0] w_mask_i,
  input  logic [ASID_W-1:0] w_asid_i,
  input  logic              w_glob_i,
  input  logic [ADDR_W-1:0] w_pfn0_i,
  input  logic              w_v0_i,
  input  logic              w_d0_i,
  input  logic [ADDR_W-1:0] w_pfn1_i,
  input  logic              w_v1_i,
  input  logic              w_d1_i,
  input  logic [ADDR_W-1:0] va_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] emask_o,
  output logic [ADDR_W-1:0] pfn0_o,
  output logic              v0_o,
  output logic              d0_o,
  output logic [ADDR_W-1:0] pfn1_o,
  output logic              v1_o,
  output logic              d1_o
);
  // pair span of two minimum pages is always masked
  localparam logic [ADDR_W-1:0] MIN_MASK =
    {{(ADDR_W-PAGE_LSB-1){1'b0}}, {(PAGE_LSB+1){1'b1}}};
  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(IDX);

  logic [ADDR_W-1:0] tag_q, mask_q, pfn0_q, pfn1_q;
  logic [ASID_W-1:0] asid_q;
  logic              glob_q, v0_q, d0_q, v1_q, d1_q;
  logic              sel_wr;

  assign sel_wr = we_i && (widx_i == MY_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q  <= '0;
      mask_q <= '0;
      asid_q <= '0;
      glob_q <= 1'b0;
      pfn0_q <= '0;
      v0_q   <= 1'b0;
      d0_q   <= 1'b0;
      pfn1_q <= '0;
      v1_q   <= 1'b0;
      d1_q   <= 1'b0;
    end else if (sel_wr) begin
      tag_q  <= w_tag_i;
      mask_q <= w_mask_i;
      asid_q <= w_asid_i;
      glob_q <= w_glob_i;
      pfn0_q <= w_pfn0_i;
      v0_q   <= w_v0_i;
      d0_q   <= w_d0_i;
      pfn1_q <= w_pfn1_i;
      v1_q   <= w_v1_i;
      d1_q   <= w_d1_i;
    end
  end

  logic [ADDR_W-1:0] emask;
  logic              tag_eq, asid_ok;

  assign emask   = mask_q | MIN_MASK;
  assign tag_eq  = ((va_i ^ tag_q) & ~emask) == '0;
  assign asid_ok = glob_q || (asid_q == asid_i);
  assign hit_o   = tag_eq && asid_ok;
  assign emask_o = emask;
  assign pfn0_o  = pfn0_q;
  assign v0_o    = v0_q;
  assign d0_o    = d0_q;
  assign pfn1_o  = pfn1_q;
  assign v1_o    = v1_q;
  assign d1_o    = d1_q;
endmodule

// File: rtl/pair_tlb_pick.sv
module pair_tlb_pick #(
  parameter int N_ENT = 16,
  parameter int IDX_W = 4
) (
  input  logic [N_ENT-1:0] hit_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // scan downward so the lowest index is written last
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pair_tlb_resolve.sv
module pair_tlb_resolve
  import pair_tlb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              any_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] va_i,
  input  logic [ADDR_W-1:0] emask_i,
  input  logic [ADDR_W-1:0] pfn0_i,
  input  logic              v0_i,
  input  logic              d0_i,
  input  logic [ADDR_W-1:0] pfn1_i,
  input  logic              v1_i,
  input  logic              d1_i,
  output logic [ADDR_W-1:0] pa_o,
  output logic              writable_o,
  output res_e              res_o
);
  logic [ADDR_W-1:0] half, top_bit, pfn_sel;
  logic              odd, v_sel, d_sel;

  assign half    = emask_i >> 1;
  assign top_bit = emask_i & ~half;
  assign odd     = |(va_i & top_bit);
  assign pfn_sel = odd ? pfn1_i : pfn0_i;
  assign v_sel   = odd ? v1_i : v0_i;
  assign d_sel   = odd ? d1_i : d0_i;

  always_comb begin
    res_o      = RES_MATCH;
    pa_o       = '0;
    writable_o = 1'b0;
    if (!any_i)            res_o = RES_MISS;
    else if (!v_sel)       res_o = RES_INVAL;
    else if (wr_i && !d_sel) res_o = RES_DIRTY;
    else begin
      pa_o       = pfn_sel | (va_i & half);
      writable_o = d_sel;
    end
  end
endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
  import pair_tlb_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int ASID_W   = 8,
  parameter int N_ENT    = 16,
  parameter int PAGE_LSB = 12,
  localparam int IDX_W   = $clog2(N_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [ADDR_W-1:0] w_tag_i,
  input  logic [ADDR_W-1:0] w_mask_i,
  input  logic [ASID_W-1:0] w_asid_i,
  input  logic              w_glob_i,
  input  logic [ADDR_W-1:0] w_pfn0_i,
  input  logic              w_v0_i,
  input  logic              w_d0_i,
  input  logic [ADDR_W-1:0] w_pfn1_i,
  input  logic              w_v1_i,
  input  logic              w_d1_i,
  input  logic [ADDR_W-1:0] va_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              wr_i,
  output logic [ADDR_W-1:0] pa_o,
  output logic              writable_o,
  output logic [2:0]        res_o
);
  logic [N_ENT-1:0]  hit;
  logic [ADDR_W-1:0] emask_a [N_ENT];
  logic [ADDR_W-1:0] pfn0_a  [N_ENT];
  logic [ADDR_W-1:0] pfn1_a  [N_ENT];
  logic [N_ENT-1:0]  v0_a, d0_a, v1_a, d1_a;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    pair_tlb_entry #(
      .ADDR_W(ADDR_W), .ASID_W(ASID_W), .PAGE_LSB(PAGE_LSB),
      .IDX_W(IDX_W), .IDX(g)
    ) ent_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we_i),
      .widx_i  (widx_i),
      .w_tag_i (w_tag_i),
      .w_mask_i(w_mask_i),
      .w_asid_i(w_asid_i),
      .w_glob_i(w_glob_i),
      .w_pfn0_i(w_pfn0_i),
      .w_v0_i  (w_v0_i),
      .w_d0_i  (w_d0_i),
      .w_pfn1_i(w_pfn1_i),
      .w_v1_i  (w_v1_i),
      .w_d1_i  (w_d1_i),
      .va_i    (va_i),
      .asid_i  (asid_i),
      .hit_o   (hit[g]),
      .emask_o (emask_a[g]),
      .pfn0_o  (pfn0_a[g]),
      .v0_o    (v0_a[g]),
      .d0_o    (d0_a[g]),
      .pfn1_o  (pfn1_a[g]),
      .v1_o    (v1_a[g]),
      .d1_o    (d1_a[g])
    );
  end

  logic             any_hit;
  logic [IDX_W-1:0] win;

  pair_tlb_pick #(.N_ENT(N_ENT), .IDX_W(IDX_W)) pick_i (
    .hit_i(hit),
    .any_o(any_hit),
    .idx_o(win)
  );

  res_e res;

  pair_tlb_resolve #(.ADDR_W(ADDR_W)) resolve_i (
    .any_i     (any_hit),
    .wr_i      (wr_i),
    .va_i      (va_i),
    .emask_i   (emask_a[win]),
    .pfn0_i    (pfn0_a[win]),
    .v0_i      (v0_a[win]),
    .d0_i      (d0_a[win]),
    .pfn1_i    (pfn1_a[win]),
    .v1_i      (v1_a[win]),
    .d1_i      (d1_a[win]),
    .pa_o      (pa_o),
    .writable_o(writable_o),
    .res_o     (res)
  );

  assign res_o = res;
endmodule

// File: rtl/pair_tlb_chk.sv
module pair_tlb_chk #(
  parameter int ADDR_W = 32,
  parameter int ASID_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] va_i,
  input logic [ASID_W-1:0] asid_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] pa_o,
  input logic              writable_o,
  input logic [2:0]        res_o
);
  assert_code_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_o <= 3'b011);

  assert_fault_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_o != 3'b000) |-> (pa_o == '0 && !writable_o));

  assert_dirty_on_store_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_o == 3'b011) |-> wr_i);

  assert_store_match_writable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_o == 3'b000 && wr_i) |-> writable_o);

  assert_hold_without_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(we_i) && $stable(va_i) && $stable(asid_i) && $stable(wr_i))
      |-> ($stable(res_o) && $stable(pa_o) && $stable(writable_o)));
endmodule

bind pair_tlb pair_tlb_chk #(.ADDR_W(ADDR_W), .ASID_W(ASID_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .va_i      (va_i),
  .asid_i    (asid_i),
  .wr_i      (wr_i),
  .pa_o      (pa_o),
  .writable_o(writable_o),
  .res_o     (res_o)
);

// File: tb/pair_tlb_tb_top.sv
module pair_tlb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  widx = '0;
  logic [31:0] w_tag = '0, w_mask = '0, w_pfn0 = '0, w_pfn1 = '0;
  logic [7:0]  w_asid = '0;
  logic        w_glob = 1'b0, w_v0 = 1'b0, w_d0 = 1'b0, w_v1 = 1'b0, w_d1 = 1'b0;
  logic [31:0] va = '0;
  logic [7:0]  asid = '0;
  logic        wr = 1'b0;
  logic [31:0] pa;
  logic        wbl;
  logic [2:0]  res;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pair_tlb dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .widx_i(widx),
    .w_tag_i(w_tag), .w_mask_i(w_mask), .w_asid_i(w_asid), .w_glob_i(w_glob),
    .w_pfn0_i(w_pfn0), .w_v0_i(w_v0), .w_d0_i(w_d0),
    .w_pfn1_i(w_pfn1), .w_v1_i(w_v1), .w_d1_i(w_d1),
    .va_i(va), .asid_i(asid), .wr_i(wr),
    .pa_o(pa), .writable_o(wbl), .res_o(res)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic set_ent(input logic [3:0] i, input logic [31:0] tg, mk,
                         input logic [7:0] as, input logic g,
                         input logic [31:0] p0, input logic v0, d0,
                         input logic [31:0] p1, input logic v1, d1);
    widx = i; w_tag = tg; w_mask = mk; w_asid = as; w_glob = g;
    w_pfn0 = p0; w_v0 = v0; w_d0 = d0; w_pfn1 = p1; w_v1 = v1; w_d1 = d1;
  endtask

  task automatic load(input logic [3:0] i, input logic [31:0] tg, mk,
                      input logic [7:0] as, input logic g,
                      input logic [31:0] p0, input logic v0, d0,
                      input logic [31:0] p1, input logic v1, d1);
    @(negedge clk);
    set_ent(i, tg, mk, as, g, p0, v0, d0, p1, v1, d1);
    we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic cmp(input string req, input logic [2:0] er,
                     input logic [31:0] ep, input logic ew);
    n_chk++;
    if (res !== er || pa !== ep || wbl !== ew) begin
      n_bad++;
      $display("FAIL %s va=%h: got res=%0d pa=%h w=%0b exp res=%0d pa=%h w=%0b",
               req, va, res, pa, wbl, er, ep, ew);
    end
  endtask

  task automatic look(input string req, input logic [31:0] a, input logic [7:0] s,
                      input logic w, input logic [2:0] er,
                      input logic [31:0] ep, input logic ew);
    @(negedge clk);
    va = a; asid = s; wr = w;
    #1;
    cmp(req, er, ep, ew);
  endtask

  task automatic t_reset;
    look("R1", 32'h0000_1234, 8'h00, 1'b0, 3'd2, 32'h0, 1'b0);
    look("R1", 32'h0000_1234, 8'h05, 1'b0, 3'd1, 32'h0, 1'b0);
    look("R1", 32'h0040_0000, 8'h00, 1'b1, 3'd1, 32'h0, 1'b0);
  endtask

  task automatic t_basic;
    load(4'd3, 32'h0040_0000, 32'h0, 8'h12, 1'b0,
         32'h0010_0000, 1'b1, 1'b1, 32'h0020_0000, 1'b1, 1'b0);
    look("R7", 32'h0040_0ABC, 8'h12, 1'b0, 3'd0, 32'h0010_0ABC, 1'b1);
    look("R4", 32'h0040_1ABC, 8'h12, 1'b0, 3'd0, 32'h0020_0ABC, 1'b0);
    look("R2", 32'h0040_0ABC, 8'h13, 1'b0, 3'd1, 32'h0, 1'b0);
    look("R2", 32'h0040_2000, 8'h12, 1'b0, 3'd1, 32'h0, 1'b0);
  endtask

  task automatic t_global;
    load(4'd4, 32'h0080_0000, 32'h0, 8'h00, 1'b1,
         32'h0300_0000, 1'b1, 1'b1, 32'h0, 1'b0, 1'b0);
    look("R2", 32'h0080_0123, 8'h77, 1'b1, 3'd0, 32'h0300_0123, 1'b1);
  endtask

  task automatic t_faults;
    look("R6", 32'h0040_1000, 8'h12, 1'b1, 3'd3, 32'h0, 1'b0);
    look("R6", 32'h0040_1000, 8'h12, 1'b0, 3'd0, 32'h0020_0000, 1'b0);
    load(4'd6, 32'h00A0_0000, 32'h0, 8'h12, 1'b0,
         32'h0900_0000, 1'b0, 1'b1, 32'h0A00_0000, 1'b0, 1'b1);
    look("R5", 32'h00A0_0010, 8'h12, 1'b0, 3'd2, 32'h0, 1'b0);
    look("R5", 32'h00A0_0010, 8'h12, 1'b1, 3'd2, 32'h0, 1'b0);
    look("R8", 32'h00A0_1010, 8'h12, 1'b1, 3'd2, 32'h0, 1'b0);
  endtask

  task automatic t_mask;
    load(4'd7, 32'h0100_0000, 32'h0000_6000, 8'h12, 1'b0,
         32'h0400_0000, 1'b1, 1'b1, 32'h0500_0000, 1'b1, 1'b1);
    look("R4", 32'h0100_3FFC, 8'h12, 1'b0, 3'd0, 32'h0400_3FFC, 1'b1);
    look("R4", 32'h0100_1000, 8'h12, 1'b1, 3'd0, 32'h0400_1000, 1'b1);
    look("R4", 32'h0100_5004, 8'h12, 1'b0, 3'd0, 32'h0500_1004, 1'b1);
    look("R3", 32'h0100_8000, 8'h12, 1'b0, 3'd1, 32'h0, 1'b0);
    load(4'd8, 32'h0200_1FFF, 32'h0, 8'h00, 1'b1,
         32'h0600_0000, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0);
    look("R3", 32'h0200_0004, 8'h44, 1'b0, 3'd0, 32'h0600_0004, 1'b0);
  endtask

  task automatic t_prio;
    load(4'd9, 32'h0300_0000, 32'h0, 8'h00, 1'b1,
         32'h0800_0000, 1'b1, 1'b1, 32'h0, 1'b0, 1'b0);
    load(4'd2, 32'h0300_0000, 32'h0, 8'h00, 1'b1,
         32'h0700_0000, 1'b1, 1'b1, 32'h0, 1'b0, 1'b0);
    look("R9", 32'h0300_0040, 8'h01, 1'b0, 3'd0, 32'h0700_0040, 1'b1);
    load(4'd2, 32'h0F00_0000, 32'h0, 8'h00, 1'b1,
         32'h0700_0000, 1'b1, 1'b1, 32'h0, 1'b0, 1'b0);
    look("R9", 32'h0300_0040, 8'h01, 1'b0, 3'd0, 32'h0800_0040, 1'b1);
  endtask

  task automatic t_write_timing;
    @(negedge clk);
    set_ent(4'd5, 32'h00C0_0000, 32'h0, 8'h12, 1'b0,
            32'h0B00_0000, 1'b1, 1'b1, 32'h0, 1'b0, 1'b0);
    we = 1'b1;
    va = 32'h00C0_0010; asid = 8'h12; wr = 1'b0;
    #1;
    cmp("R10", 3'd1, 32'h0, 1'b0);
    @(negedge clk);
    we = 1'b0;
    #1;
    cmp("R10", 3'd0, 32'h0B00_0010, 1'b1);
    look("R10", 32'h0040_0ABC, 8'h12, 1'b0, 3'd0, 32'h0010_0ABC, 1'b1);
    look("R11", 32'h0080_0000, 8'h00, 1'b0, 3'd0, 32'h0300_0000, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_global();
    t_faults();
    t_mask();
    t_prio();
    t_write_timing();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule